// File: doc/BRIEF.md
# Sub-word Load/Store Memory Port

This block is a small data memory built from 64-bit rows. Software-visible accesses use byte addresses and may be one, two, four or eight bytes wide. The low three address bits select a byte lane inside a row. The bits above them select the row. A store narrower than a row merges its bytes into the row currently held and leaves every other lane as it was. A load narrower than a row pulls the addressed lanes down to bit 0 and zero-fills the bits above.

Each request may ask for byte reversal over the access width. This lets one port serve both byte orders. An access whose lane offset is not a multiple of its width is refused. A refused store leaves the memory untouched. A refused load returns zero. In both cases the error flag is raised.

Each request gives exactly one response, registered, in the following cycle.

Top module: `subword_mem_port`

## Requirements
- R1: The byte address is split so that bits [2:0] are the lane offset (lane 0 holds row bits [7:0]) and the upper bits are the row index. The highest row and its highest lane are reachable.
- R2: The size code is 0 for a byte, 1 for a halfword, 2 for a word and 3 for a doubleword. An access whose offset is not a multiple of its byte count sets rsp_misalign. An aligned access leaves rsp_misalign clear.
- R3: A misaligned store changes no memory byte. A misaligned load returns rsp_rdata of zero.
- R4: An aligned narrow store writes only the addressed lanes. All other bytes of the row keep their previous values.
- R5: An aligned narrow load returns the addressed lanes in the low bits of rsp_rdata, with lane offset+k at byte k. All higher bits are zero.
- R6: With req_swap set, a load returns the extracted bytes reversed over the access width.
- R7: With req_swap set, a store reverses the low bytes of the write data over the access width before merging them.
- R8: After reset, every row reads as zero until it is written.
- R9: A doubleword access reads or writes the whole 64-bit row.
- R10: rsp_valid is high in exactly the cycle after each cycle with req_valid high. A store response carries rsp_rdata of zero. A store is visible to a load issued in the next cycle.
- R11: Write-data bits above the access width have no effect on memory.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| req_addr | input | ADDR_W (7) | Byte address |
| req_size | input | 2 | Access size code: 0 byte, 1 half, 2 word, 3 double |
| req_write | input | 1 | 1 for a store, 0 for a load |
| req_wdata | input | 64 | Store data, right-justified |
| req_swap | input | 1 | Reverse bytes over the access width |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | 64 | Load data, right-justified; zero for stores and errors |
| rsp_misalign | output | 1 | The request was misaligned and was refused |

## Verification
The assertions assume that the request inputs are held at known values whenever the clock samples them. They also assume the address never exceeds the parameterised row count. They place no limit on request rate, because one request per cycle is legal.

The stimulus drives every request field on the falling edge and issues requests back to back. It keeps addresses inside the configured memory, and it mixes aligned and misaligned offsets for every size, so the properties on refused stores and on response timing are exercised.

// File: rtl/subword_mem_pkg.sv
package subword_mem_pkg;
  localparam int unsigned ROW_BYTES = 8;
  localparam int unsigned ROW_BITS  = ROW_BYTES * 8;
  localparam int unsigned LANE_W    = $clog2(ROW_BYTES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } acc_size_e;

  typedef logic [ROW_BITS-1:0] row_t;
endpackage

// File: rtl/subword_align_chk.sv
module subword_align_chk
  import subword_mem_pkg::*;
(
  input  logic [LANE_W-1:0] lane_off,
  input  acc_size_e         size,
  output logic              bad
);
  always_comb begin
    unique case (size)
      SZ_BYTE: bad = 1'b0;
      SZ_HALF: bad = lane_off[0];
      SZ_WORD: bad = |lane_off[1:0];
      default: bad = |lane_off;
    endcase
  end
endmodule

// File: rtl/subword_byte_rev.sv
module subword_byte_rev
  import subword_mem_pkg::*;
(
  input  row_t      din,
  input  acc_size_e size,
  input  logic      en,
  output row_t      dout
);
  logic [LANE_W-1:0] last_lane;

  always_comb begin
    unique case (size)
      SZ_BYTE: last_lane = 3'd0;
      SZ_HALF: last_lane = 3'd1;
      SZ_WORD: last_lane = 3'd3;
      default: last_lane = 3'd7;
    endcase
  end

  for (genvar i = 0; i < ROW_BYTES; i++) begin : g_lane
    logic [LANE_W-1:0] src;
    logic [7:0]        rev_byte;
    always_comb begin
      src = last_lane - LANE_W'(i);
      if (LANE_W'(i) <= last_lane) rev_byte = din[src*8 +: 8];
      else                         rev_byte = 8'h00;
    end
    assign dout[i*8 +: 8] = en ? rev_byte : din[i*8 +: 8];
  end
endmodule

// File: rtl/subword_lane_unit.sv
module subword_lane_unit
  import subword_mem_pkg::*;
(
  input  row_t              row,
  input  logic [LANE_W-1:0] lane_off,
  input  acc_size_e         size,
  input  row_t              wdata,
  output row_t              load_val,
  output row_t              merged
);
  logic [5:0] shamt;
  row_t       width_mask;
  row_t       lane_mask;

  always_comb begin
    shamt = {lane_off, 3'b000};
    unique case (size)
      SZ_BYTE: width_mask = 64'h0000_0000_0000_00FF;
      SZ_HALF: width_mask = 64'h0000_0000_0000_FFFF;
      SZ_WORD: width_mask = 64'h0000_0000_FFFF_FFFF;
      default: width_mask = '1;
    endcase
    lane_mask = width_mask << shamt;
  end

  always_comb begin
    if (size == SZ_DBL) begin
      load_val = row;
      merged   = wdata;
    end else begin
      load_val = (row >> shamt) & width_mask;
      merged   = (row & ~lane_mask) | ((wdata & width_mask) << shamt);
    end
  end
endmodule

// File: rtl/subword_mem_port.sv
module subword_mem_port
  import subword_mem_pkg::*;
#(
  parameter int unsigned ROWS   = 16,
  localparam int unsigned ROW_W  = $clog2(ROWS),
  localparam int unsigned ADDR_W = ROW_W + LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_write,
  input  logic [63:0]       req_wdata,
  input  logic              req_swap,
  output logic              rsp_valid,
  output logic [63:0]       rsp_rdata,
  output logic              rsp_misalign
);
  logic [ROWS-1:0][ROW_BITS-1:0] mem_q, mem_d;

  logic [ROW_W-1:0]  row_idx;
  logic [LANE_W-1:0] lane_off;
  acc_size_e         size;
  logic              mis_c;
  logic              wr_en;
  row_t              cur_row, st_data, ld_raw, ld_final, merged_row;
  row_t              rdata_d;

  assign row_idx  = req_addr[ADDR_W-1:LANE_W];
  assign lane_off = req_addr[LANE_W-1:0];
  assign size     = acc_size_e'(req_size);
  assign cur_row  = mem_q[row_idx];

  subword_align_chk u_align (
    .lane_off (lane_off),
    .size     (size),
    .bad      (mis_c)
  );

  subword_byte_rev u_st_rev (
    .din  (req_wdata),
    .size (size),
    .en   (req_swap),
    .dout (st_data)
  );

  subword_lane_unit u_lanes (
    .row      (cur_row),
    .lane_off (lane_off),
    .size     (size),
    .wdata    (st_data),
    .load_val (ld_raw),
    .merged   (merged_row)
  );

  subword_byte_rev u_ld_rev (
    .din  (ld_raw),
    .size (size),
    .en   (req_swap),
    .dout (ld_final)
  );

  assign wr_en   = req_valid & req_write & ~mis_c;
  assign rdata_d = (req_write | mis_c) ? '0 : ld_final;

  always_comb begin
    mem_d = mem_q;
    if (wr_en) mem_d[row_idx] = merged_row;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mem_q <= '0;
    else if (wr_en) mem_q <= mem_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_rdata    <= '0;
      rsp_misalign <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_rdata    <= rdata_d;
        rsp_misalign <= mis_c;
      end
    end
  end

  // R10
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  // R10
  idle_no_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  // R3
  bad_store_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && mis_c) |=> $stable(mem_q));
  // R3
  bad_load_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_misalign) |-> (rsp_rdata == 64'd0));
  // R4
  no_req_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_write) |=> $stable(mem_q));
  // R2
  byte_never_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size == 2'd0) |=> !rsp_misalign);
  // R5
  byte_load_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_size == 2'd0) |=> (rsp_rdata[63:8] == 56'd0));
  // R10
  store_rsp_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |=> (rsp_rdata == 64'd0));
endmodule

// File: tb/subword_mem_port_test.sv
module subword_mem_port_test;
  localparam int ROWS  = 16;
  localparam int BYTES = ROWS * 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [6:0]  req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        req_write = 1'b0;
  logic [63:0] req_wdata = '0;
  logic        req_swap = 1'b0;
  logic        rsp_valid;
  logic [63:0] rsp_rdata;
  logic        rsp_misalign;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [7:0]  ref_mem [BYTES];
  logic [63:0] q_data [$];
  logic        q_mis [$];
  string       q_tag [$];

  always #10 clk = ~clk;

  subword_mem_port #(.ROWS(ROWS)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
    .req_swap(req_swap), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_misalign(rsp_misalign)
  );

  task automatic issue(input int addr, input int sz, input bit wr,
                       input logic [63:0] wd, input bit sw, input string tag);
    int nb;
    bit mis;
    logic [63:0] exp;
    nb  = 1 << sz;
    mis = (addr % nb) != 0;
    exp = '0;
    if (!mis) begin
      for (int k = 0; k < nb; k++) begin
        int src;
        src = sw ? (nb - 1 - k) : k;
        if (wr) ref_mem[addr + k] = wd[src*8 +: 8];
        else    exp[k*8 +: 8] = ref_mem[addr + src];
      end
    end
    req_valid = 1'b1;
    req_addr  = 7'(addr);
    req_size  = 2'(sz);
    req_write = wr;
    req_wdata = wd;
    req_swap  = sw;
    q_data.push_back(exp);
    q_mis.push_back(mis);
    q_tag.push_back(tag);
    @(negedge clk);
  endtask

  task automatic go_idle();
    req_valid = 1'b0;
    req_wdata = '0;
    @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      checks++;
      if (q_data.size() == 0) begin
        fails++;
        $display("FAIL R10: unexpected response rdata=%h, expected none", rsp_rdata);
      end else begin
        logic [63:0] e;
        logic        m;
        string       t;
        e = q_data.pop_front();
        m = q_mis.pop_front();
        t = q_tag.pop_front();
        if (rsp_rdata !== e || rsp_misalign !== m) begin
          fails++;
          $display("FAIL %s: rdata=%h misalign=%b, expected rdata=%h misalign=%b",
                   t, rsp_rdata, rsp_misalign, e, m);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < BYTES; i++) ref_mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0 || rsp_rdata !== 64'd0) begin
      fails++;
      $display("FAIL R10: reset rsp_valid=%b rdata=%h, expected 0 and 0", rsp_valid, rsp_rdata);
    end
    rst_n = 1'b1;
    @(negedge clk);

    issue(8'h00, 3, 0, 64'd0, 0, "R8 unwritten row");
    issue(8'h38, 2, 0, 64'd0, 0, "R8 unwritten word");
    issue(8'h08, 3, 1, 64'h1122334455667788, 0, "R9 store double");
    issue(8'h08, 3, 0, 64'd0, 0, "R9 load double");
    issue(8'h0B, 0, 1, 64'hDEADBEEF_CAFE00AA, 0, "R11 byte store");
    issue(8'h08, 3, 0, 64'd0, 0, "R4 R11 row after byte store");
    for (int a = 8; a < 16; a++) issue(a, 0, 0, 64'd0, 0, "R5 byte load");
    issue(8'h0A, 1, 0, 64'd0, 0, "R5 half load");
    issue(8'h0C, 2, 0, 64'd0, 0, "R5 word load");
    issue(8'h0E, 1, 1, 64'hFFFF_FFFF_FFFF_1357, 0, "R4 half store");
    issue(8'h08, 3, 0, 64'd0, 0, "R4 R10 back-to-back readback");
    issue(8'h0A, 1, 0, 64'd0, 1, "R6 half swap load");
    issue(8'h0C, 2, 0, 64'd0, 1, "R6 word swap load");
    issue(8'h08, 3, 0, 64'd0, 1, "R6 double swap load");
    issue(8'h14, 2, 1, 64'h0BAD_F00D_A1B2C3D4, 1, "R7 word swap store");
    issue(8'h10, 3, 0, 64'd0, 0, "R7 row after swap store");
    issue(8'h18, 3, 1, 64'h0102030405060708, 1, "R7 R9 double swap store");
    issue(8'h18, 3, 0, 64'd0, 0, "R7 R9 readback");
    issue(8'h09, 1, 1, 64'h0000_0000_0000_EEEE, 0, "R2 R3 misaligned half store");
    issue(8'h0A, 2, 1, 64'h0000_0000_7777_7777, 0, "R2 R3 misaligned word store");
    issue(8'h0C, 3, 1, 64'h5555_5555_5555_5555, 0, "R2 R3 misaligned double store");
    issue(8'h08, 3, 0, 64'd0, 0, "R3 row unchanged");
    issue(8'h0A, 2, 0, 64'd0, 0, "R2 R3 misaligned word load");
    issue(8'h0F, 1, 0, 64'd0, 1, "R2 R3 misaligned half swap load");
    issue(8'h7F, 0, 1, 64'h0000_0000_0000_00C3, 0, "R1 top byte store");
    issue(8'h7C, 2, 0, 64'd0, 0, "R1 top word load");
    issue(8'h78, 3, 0, 64'd0, 0, "R1 top row load");
    go_idle();
    go_idle();
    checks++;
    if (q_data.size() != 0 || rsp_valid !== 1'b0) begin
      fails++;
      $display("FAIL R10: pending=%0d rsp_valid=%b, expected 0 and 0", q_data.size(), rsp_valid);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule